// File: doc/BRIEF.md
# Legacy Interrupt Pulse Aggregator with End-of-Interrupt Re-trigger

This block merges four level-sensitive legacy interrupt lines from a PCIe controller into one pulse-type interrupt line for a system interrupt controller. A pulse line cannot hold a level. A handler that returns while a source is still asserted would therefore never be invoked again. To prevent this, software writes an end-of-interrupt code once it has finished servicing. The block then looks again at the enabled sources that are still asserted and, if any remain, fires a fresh pulse.

Software reaches the block through a small synchronous register bus. One register holds a per-source enable mask. One read-only register shows the captured raw input levels. A write-only end-of-interrupt register accepts a source code, and only the legacy code acts on this logic. A parameter selects a second behaviour with no re-trigger. In that mode a pulse is issued on every change of the enabled input set, covering both assertion and deassertion, and end-of-interrupt writes are ignored.

Top module: `intx_pulse_merge`

## Requirements
- R1: After reset is released, the pulse output is low and the enable register reads as zero.
- R2: The enable register is at offset 0x104, and source n (0 to 3) uses bit 22+n. The other bits read as zero, and writes to them have no effect.
- R3: The status register is at offset 0x504, and bit 22+n shows the captured level of source n whether or not the source is enabled. Its other bits read as zero. Any unmapped offset reads as zero. Read data appears one clock edge after the address is presented.
- R4: In re-trigger mode, a one-cycle pulse is issued when the OR over all sources of (level AND enable) goes from 0 to 1. The pulse is high after the second clock edge that follows the input change.
- R5: In re-trigger mode, no pulse is issued when the enabled pending set falls, whether an input deasserts or an enable is cleared.
- R6: In re-trigger mode, a write of exactly the value 2 to offset 0xC8 fires a pulse after that same edge if any enabled source is asserted. With nothing pending, the write fires nothing.
- R7: Writes of the codes 0, 1 and 3 to offset 0xC8 never produce a pulse.
- R8: Setting the enable of a source whose input is already asserted produces a pulse two edges after the write, provided nothing enabled was pending before.
- R9: Every pulse is exactly one clock wide, and the output is never high on two consecutive cycles.
- R10: With re-trigger disabled, a pulse follows any change of the enabled level vector, including assertion, deassertion and enable changes. End-of-interrupt writes are ignored in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| intx_i | input | 4 | Legacy interrupt levels, bit n is source n |
| bus_addr_i | input | 12 | Register byte offset |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the address of the previous cycle |
| irq_pulse_o | output | 1 | One-cycle interrupt pulse |

## Verification
Input levels pass through one capture register before the pulse register, so an input-driven pulse is due on the second edge after the change. An enable write likewise produces its pulse on the second edge, because the new mask is registered first. An end-of-interrupt write acts on the first edge, and read data is also due on the first edge. The bench drives every stimulus on a falling edge and samples on the following falling edges. At each sample it checks that the output is low before the due edge, at the expected value on that edge, and low again one edge later. The sweep covers all 256 combinations of enable mask and input pattern, for both parameter settings at once.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam logic [11:0] OFS_EOI    = 12'h0C8;
  localparam logic [11:0] OFS_ENABLE = 12'h104;
  localparam logic [11:0] OFS_STATUS = 12'h504;

  typedef enum logic [1:0] {
    EOI_DOWNSTREAM = 2'd0,
    EOI_FUNC_RESET = 2'd1,
    EOI_LEGACY     = 2'd2,
    EOI_POWER      = 2'd3
  } eoi_src_e;
endpackage

// File: rtl/intx_regs.sv
module intx_regs
  import intx_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int FIELD_LSB = 22,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic               eoi_legacy_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(OFS_EOI);

  logic [NUM_SRC-1:0] en_q, en_d;
  logic               en_wr;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               live_q;

  always_comb begin
    en_wr        = we_i && (addr_i == A_EN);
    en_d         = wdata_i[FIELD_LSB +: NUM_SRC];
    eoi_legacy_o = we_i && (addr_i == A_EOI) &&
                   (wdata_i == DATA_W'(EOI_LEGACY));
    rdata_d      = '0;
    if (addr_i == A_EN)
      rdata_d[FIELD_LSB +: NUM_SRC] = en_q;
    else if (addr_i == A_STAT)
      rdata_d[FIELD_LSB +: NUM_SRC] = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      rdata_q <= '0;
      live_q  <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_d;
      rdata_q <= rdata_d;
      live_q  <= 1'b1;
    end
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;

  // R2: the mask changes only through a write to its offset
  p_en_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    !$past(en_wr) |-> $stable(en_q));

  // R3: a status read returns the captured levels of the previous cycle
  p_stat_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    $past(addr_i == A_STAT) |-> rdata_o[FIELD_LSB +: NUM_SRC] == $past(lvl_i));
endmodule

// File: rtl/intx_trig.sv
module intx_trig #(
  parameter int NUM_SRC       = 4,
  parameter bit EOI_RETRIGGER = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               eoi_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] masked;
  logic               pend;
  logic               fire;
  logic               irq_q, irq_d;
  logic               live_q;

  assign masked = lvl_i & en_i;
  assign pend   = |masked;

  generate
    if (EOI_RETRIGGER) begin : g_level
      logic pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= pend;
      end
      assign fire = (pend && !pend_q) || (eoi_i && pend);

      // R4: a pulse needs an enabled source that was asserted
      p_needs_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
        irq_q |-> $past(pend));
      // R6: a legacy EOI with work pending and a free output re-fires
      p_eoi_refire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
        $past(eoi_i && pend && !irq_q) |-> irq_q);
    end else begin : g_edge
      logic [NUM_SRC-1:0] masked_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) masked_q <= '0;
        else         masked_q <= masked;
      end
      assign fire = |(masked ^ masked_q);

      // R10: a pulse needs a change in the enabled level vector
      p_needs_change_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
        irq_q |-> $past(masked) != $past(masked_q));
    end
  endgenerate

  always_comb irq_d = fire && !irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      live_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R9: never two high cycles in a row
  p_one_wide_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/intx_pulse_merge.sv
module intx_pulse_merge #(
  parameter int NUM_SRC       = 4,
  parameter int FIELD_LSB     = 22,
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32,
  parameter bit EOI_RETRIGGER = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] intx_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_pulse_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic [NUM_SRC-1:0] lvl_q;
  logic [NUM_SRC-1:0] en;
  logic               eoi_legacy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) lvl_q <= '0;
    else          lvl_q <= intx_i;
  end

  intx_regs #(
    .NUM_SRC(NUM_SRC), .FIELD_LSB(FIELD_LSB), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n_s), .addr_i(bus_addr_i), .we_i(bus_we_i),
    .wdata_i(bus_wdata_i), .lvl_i(lvl_q), .en_o(en),
    .eoi_legacy_o(eoi_legacy), .rdata_o(bus_rdata_o)
  );

  intx_trig #(
    .NUM_SRC(NUM_SRC), .EOI_RETRIGGER(EOI_RETRIGGER)
  ) u_trig (
    .clk_i(clk_i), .rst_ni(rst_n_s), .lvl_i(lvl_q), .en_i(en),
    .eoi_i(eoi_legacy), .irq_o(irq_pulse_o)
  );

  // R1: output held low while reset is active
  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_n_s |-> !irq_pulse_o);
endmodule

// File: tb/sim_intx_pulse_merge.sv
`timescale 1ns/1ps
module sim_intx_pulse_merge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  intx;
  logic [11:0] addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  intx_pulse_merge #(.EOI_RETRIGGER(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .intx_i(intx), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata0), .irq_pulse_o(irq0));

  intx_pulse_merge #(.EOI_RETRIGGER(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .intx_i(intx), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata1), .irq_pulse_o(irq1));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    tick();
    we = 1'b0; wdata = '0; addr = 12'h000;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a; we = 1'b0;
    tick();
    chk({tag, " u0 rdata"}, rdata0, exp);
    chk({tag, " u1 rdata"}, rdata1, exp);
  endtask

  task automatic irqs(input string tag, input logic e0, input logic e1);
    chk({tag, " u0 irq"}, 32'(irq0), 32'(e0));
    chk({tag, " u1 irq"}, 32'(irq1), 32'(e1));
  endtask

  initial begin
    rst_n = 1'b0; intx = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    irqs("R1 reset", 1'b0, 1'b0);
    rd("R1 enable after reset", 12'h104, 32'h0);

    for (int en = 0; en < 16; en++) begin
      for (int in = 0; in < 16; in++) begin
        logic        e;
        logic [31:0] junk;
        e    = ((en & in) != 0);
        junk = (32'hA5C3_1E7F ^ 32'(in * 32'h0101_0101)) & 32'hFC3F_FFFF;
        wr(12'h104, (32'(en) << 22) | junk);
        irqs("R2 mask write idle", 1'b0, 1'b0);
        tick();
        intx = 4'(in);
        tick(); irqs("R4 capture stage", 1'b0, 1'b0);
        tick(); irqs("R4 R10 assert pulse", e, e);
        tick(); irqs("R9 pulse end", 1'b0, 1'b0);
        rd("R3 status", 12'h504, 32'(in) << 22);
        rd("R2 enable field", 12'h104, 32'(en) << 22);
        rd("R3 unmapped", 12'h200, 32'h0);
        for (int c = 0; c < 4; c++) begin
          if (c != 2) begin
            wr(12'h0C8, 32'(c));
            irqs("R7 other eoi code", 1'b0, 1'b0);
          end
        end
        wr(12'h0C8, 32'd2);
        irqs("R6 R10 legacy eoi", e, 1'b0);
        tick(); irqs("R9 eoi pulse end", 1'b0, 1'b0);
        wr(12'h104, 32'h0);
        irqs("R5 disable edge", 1'b0, 1'b0);
        tick(); irqs("R5 R10 disable pulse", 1'b0, e);
        tick();
        wr(12'h104, 32'(en) << 22);
        irqs("R8 enable edge", 1'b0, 1'b0);
        tick(); irqs("R8 R10 enable pending", e, e);
        tick();
        intx = 4'h0;
        tick(); irqs("R5 deassert stage", 1'b0, 1'b0);
        tick(); irqs("R5 R10 deassert pulse", 1'b0, e);
        tick();
        wr(12'h104, 32'h0);
        tick();
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule